// File: doc/BRIEF.md
# Page-Bin Translation Buffer with L2 Slice Steering

This block is a small fully associative translation buffer for a tiled processor with a distributed, shared L2 cache. Each entry holds a virtual page number, a physical page number and a cache-bin number. Software picks the bin when it allocates the page. A bin is the smallest group of cache sets that can hold a whole page. The number of bins is the total L2 capacity divided by the product of page size and associativity. Every block of a page lands in the bin chosen for that page. Because each slice holds several bins, the bin number alone names the target slice.

A lookup returns the physical address in the same cycle. If the core also flags an L1 miss in that cycle, the block issues an L2 request in the same cycle. The request carries the destination slice and the set index, both taken from the stored bin. This adds no lookup latency. A mode input selects a baseline instead: the slice is the block address modulo the slice count. Entries are written through a fill port and removed with an invalidate-by-page input.

The defaults describe a 16-slice L2 with 256 KB, 4-way slices, 128-byte blocks and 8 KB pages. That gives 8 bins per slice and 128 bins in total, so the bin field is 7 bits wide.

Top module: `page_bin_tlb`

## Requirements
- R1: After reset no entry is valid, so every lookup reports a miss.
- R2: On a lookup hit, lk_paddr is the stored physical page number concatenated with the 13-bit page offset of lk_vaddr. lk_hit and lk_miss are never both high. On a lookup miss, lk_miss is high and lk_paddr is zero.
- R3: An entry written through the fill port hits from the cycle after the fill.
- R4: req_valid is high only when lk_valid hits and l1_miss is high in the same cycle. When req_valid is low, req_slice and req_set are zero.
- R5: In bin mode (mode_shared=0), req_slice is bin[6:3] and req_set is {bin[2:0], lk_vaddr[12:7]}.
- R6: In shared mode (mode_shared=1), req_slice is the block address modulo 16, which is paddr[10:7], and req_set is paddr[19:11].
- R7: inv_valid clears the entry whose page number matches inv_vpn. A lookup of that page misses from the next cycle.
- R8: A fill whose page number is already present updates that entry in place. Otherwise the fill takes the lowest-numbered free entry. No other entry is disturbed.
- R9: A fill into a full buffer replaces the entry named by a round-robin pointer. The pointer is 0 after reset and advances by one, wrapping, only on such replacements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 33 | Virtual address to translate |
| l1_miss | input | 1 | L1 miss for this access; request L2 |
| mode_shared | input | 1 | 1: modulo slice selection, 0: bin steering |
| fill_valid | input | 1 | Write an entry |
| fill_vpn | input | 20 | Virtual page number to write |
| fill_ppn | input | 20 | Physical page number to write |
| fill_bin | input | 7 | Cache bin assigned to the page |
| inv_valid | input | 1 | Invalidate by page number |
| inv_vpn | input | 20 | Page number to invalidate |
| lk_hit | output | 1 | Lookup hit |
| lk_miss | output | 1 | Lookup miss |
| lk_paddr | output | 33 | Translated physical address |
| req_valid | output | 1 | L2 request issued |
| req_slice | output | 4 | Destination L2 slice |
| req_set | output | 9 | Set index within the slice |

## Verification
On every cycle, the assertions check the following:
- a hit and a miss are never flagged together;
- a request never leaves without a hit and an L1 miss;
- the offset passes through to the physical address;
- the set's low bits follow the block offset in bin mode;
- the slice follows the block address in shared mode;
- a fill is visible one cycle later;
- an invalidate takes effect one cycle later.

Only the bench's scenarios can show the following:
- the choice of fill slot (update in place, lowest free entry, round-robin victim);
- the pointer's advance across successive replacements;
- which entries survive those replacements;
- the exact slice and set values derived from specific bins.

// File: rtl/page_bin_tlb.sv
module page_bin_tlb #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int OFF_W   = 13,
  parameter int BLK_W   = 7,
  parameter int BIN_W   = 7,
  parameter int SLICE_W = 4
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     lk_valid,
  input  logic [VPN_W+OFF_W-1:0]                   lk_vaddr,
  input  logic                                     l1_miss,
  input  logic                                     mode_shared,
  input  logic                                     fill_valid,
  input  logic [VPN_W-1:0]                         fill_vpn,
  input  logic [PPN_W-1:0]                         fill_ppn,
  input  logic [BIN_W-1:0]                         fill_bin,
  input  logic                                     inv_valid,
  input  logic [VPN_W-1:0]                         inv_vpn,
  output logic                                     lk_hit,
  output logic                                     lk_miss,
  output logic [PPN_W+OFF_W-1:0]                   lk_paddr,
  output logic                                     req_valid,
  output logic [SLICE_W-1:0]                       req_slice,
  output logic [BIN_W-SLICE_W+OFF_W-BLK_W-1:0]     req_set
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int LB_W  = BIN_W - SLICE_W;
  localparam int SET_W = LB_W + OFF_W - BLK_W;
  localparam int VA_W  = VPN_W + OFF_W;
  localparam int PA_W  = PPN_W + OFF_W;

  logic [ENTRIES-1:0] vld_q;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [BIN_W-1:0]   bin_q [ENTRIES];
  logic [IDX_W-1:0]   rr_q;

  wire [VPN_W-1:0] lk_vpn = lk_vaddr[VA_W-1:OFF_W];
  wire [OFF_W-1:0] lk_off = lk_vaddr[OFF_W-1:0];

  logic             hit, fmatch, free_any, use_rr;
  logic [IDX_W-1:0] hit_idx, fm_idx, free_idx, tgt;

  always_comb begin
    hit = 1'b0;      hit_idx  = '0;
    fmatch = 1'b0;   fm_idx   = '0;
    free_any = 1'b0; free_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (vld_q[i] && vpn_q[i] == lk_vpn) begin
        hit = 1'b1; hit_idx = IDX_W'(i);
      end
      if (vld_q[i] && vpn_q[i] == fill_vpn) begin
        fmatch = 1'b1; fm_idx = IDX_W'(i);
      end
    end
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        free_any = 1'b1; free_idx = IDX_W'(i);
      end
    end
    use_rr = !fmatch && !free_any;
    tgt    = fmatch ? fm_idx : (free_any ? free_idx : rr_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++)
        if (inv_valid && vld_q[i] && vpn_q[i] == inv_vpn) vld_q[i] <= 1'b0;
      if (fill_valid) vld_q[tgt] <= 1'b1;
      if (fill_valid && use_rr)
        rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_valid) begin
      vpn_q[tgt] <= fill_vpn;
      ppn_q[tgt] <= fill_ppn;
      bin_q[tgt] <= fill_bin;
    end
  end

  wire [PPN_W-1:0]   hppn = ppn_q[hit_idx];
  wire [BIN_W-1:0]   hbin = bin_q[hit_idx];
  wire [PA_W-1:0]    pa   = {hppn, lk_off};
  wire [SLICE_W-1:0] slice_sel = mode_shared ? pa[BLK_W +: SLICE_W]
                                             : hbin[BIN_W-1 -: SLICE_W];
  wire [SET_W-1:0]   set_sel   = mode_shared ? pa[BLK_W+SLICE_W +: SET_W]
                                             : {hbin[LB_W-1:0], lk_off[OFF_W-1:BLK_W]};

  assign lk_hit    = lk_valid & hit;
  assign lk_miss   = lk_valid & ~hit;
  assign lk_paddr  = lk_hit ? pa : '0;
  assign req_valid = lk_hit & l1_miss;
  assign req_slice = req_valid ? slice_sel : '0;
  assign req_set   = req_valid ? set_sel : '0;
endmodule

// File: rtl/page_bin_tlb_chk.sv
module page_bin_tlb_chk #(
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int OFF_W   = 13,
  parameter int BLK_W   = 7,
  parameter int BIN_W   = 7,
  parameter int SLICE_W = 4
) (
  input logic                                 clk,
  input logic                                 rst_n,
  input logic                                 lk_valid,
  input logic [VPN_W+OFF_W-1:0]               lk_vaddr,
  input logic                                 l1_miss,
  input logic                                 mode_shared,
  input logic                                 fill_valid,
  input logic [VPN_W-1:0]                     fill_vpn,
  input logic [PPN_W-1:0]                     fill_ppn,
  input logic                                 inv_valid,
  input logic [VPN_W-1:0]                     inv_vpn,
  input logic                                 lk_hit,
  input logic                                 lk_miss,
  input logic [PPN_W+OFF_W-1:0]               lk_paddr,
  input logic                                 req_valid,
  input logic [SLICE_W-1:0]                   req_slice,
  input logic [BIN_W-SLICE_W+OFF_W-BLK_W-1:0] req_set
);
  localparam int VA_W = VPN_W + OFF_W;
  localparam int PA_W = PPN_W + OFF_W;

  // R2
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_miss));

  // R2
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]);

  // R4
  req_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (lk_hit && l1_miss));

  // R4
  no_req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (req_slice == '0 && req_set == '0));

  // R5
  bin_set_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !mode_shared) |-> req_set[OFF_W-BLK_W-1:0] == lk_vaddr[OFF_W-1:BLK_W]);

  // R6
  shared_slice_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode_shared) |-> req_slice == lk_paddr[BLK_W +: SLICE_W]);

  // R3
  fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !inv_valid) |=>
      ((lk_valid && lk_vaddr[VA_W-1:OFF_W] == $past(fill_vpn)) ->
        (lk_hit && lk_paddr[PA_W-1:OFF_W] == $past(fill_ppn))));

  // R7
  inv_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && !fill_valid) |=>
      !(lk_valid && lk_vaddr[VA_W-1:OFF_W] == $past(inv_vpn) && lk_hit));
endmodule

bind page_bin_tlb page_bin_tlb_chk #(
  .VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W),
  .BLK_W(BLK_W), .BIN_W(BIN_W), .SLICE_W(SLICE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
  .l1_miss(l1_miss), .mode_shared(mode_shared), .fill_valid(fill_valid),
  .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .inv_valid(inv_valid),
  .inv_vpn(inv_vpn), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
  .req_valid(req_valid), .req_slice(req_slice), .req_set(req_set)
);

// File: tb/page_bin_tlb_tb.sv
module page_bin_tlb_tb;
  localparam int VPN_W = 20, PPN_W = 20, OFF_W = 13, BLK_W = 7, BIN_W = 7, SLICE_W = 4;
  localparam int SET_W = BIN_W - SLICE_W + OFF_W - BLK_W;
  localparam int VA_W = VPN_W + OFF_W, PA_W = PPN_W + OFF_W;

  logic clk = 0, rst_n = 0;
  logic lk_valid = 0, l1_miss = 0, mode_shared = 0;
  logic [VA_W-1:0] lk_vaddr = '0;
  logic fill_valid = 0, inv_valid = 0;
  logic [VPN_W-1:0] fill_vpn = '0, inv_vpn = '0;
  logic [PPN_W-1:0] fill_ppn = '0;
  logic [BIN_W-1:0] fill_bin = '0;
  logic lk_hit, lk_miss, req_valid;
  logic [PA_W-1:0] lk_paddr;
  logic [SLICE_W-1:0] req_slice;
  logic [SET_W-1:0] req_set;

  page_bin_tlb u_dut (.*);

  always #2 clk = ~clk;

  typedef struct {
    bit hit; bit miss; logic [PA_W-1:0] pa; bit req;
    logic [SLICE_W-1:0] sl; logic [SET_W-1:0] st; string tag;
  } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;

  function automatic logic [VPN_W-1:0] a_vpn(int i); return VPN_W'('h100 + i); endfunction
  function automatic logic [PPN_W-1:0] a_ppn(int i); return PPN_W'('h5000 + i * 3); endfunction
  function automatic logic [BIN_W-1:0] a_bin(int i); return BIN_W'((i * 17) % 128); endfunction

  task automatic fill(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p, input logic [BIN_W-1:0] b);
    @(negedge clk);
    lk_valid = 0; inv_valid = 0;
    fill_valid = 1; fill_vpn = v; fill_ppn = p; fill_bin = b;
  endtask

  task automatic inval(input logic [VPN_W-1:0] v);
    @(negedge clk);
    lk_valid = 0; fill_valid = 0;
    inv_valid = 1; inv_vpn = v;
  endtask

  task automatic look(input logic [VPN_W-1:0] v, input logic [OFF_W-1:0] off, input bit l1m,
                      input bit sh, input bit eh, input logic [PPN_W-1:0] p,
                      input logic [BIN_W-1:0] b, input string tag);
    exp_t e;
    logic [PA_W-1:0] pa;
    @(negedge clk);
    fill_valid = 0; inv_valid = 0;
    lk_valid = 1; lk_vaddr = {v, off}; l1_miss = l1m; mode_shared = sh;
    pa = {p, off};
    e.tag = tag; e.hit = eh; e.miss = !eh; e.pa = eh ? pa : '0;
    e.req = eh && l1m; e.sl = '0; e.st = '0;
    if (e.req) begin
      if (sh) begin e.sl = pa[10:7]; e.st = pa[19:11]; end
      else begin e.sl = b[6:3]; e.st = {b[2:0], off[12:7]}; end
    end
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk); #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (lk_hit !== e.hit || lk_miss !== e.miss || lk_paddr !== e.pa ||
            req_valid !== e.req || req_slice !== e.sl || req_set !== e.st) begin
          fails++;
          $display("FAIL %s: got hit=%b miss=%b pa=%h req=%b slice=%h set=%h, expected hit=%b miss=%b pa=%h req=%b slice=%h set=%h",
                   e.tag, lk_hit, lk_miss, lk_paddr, req_valid, req_slice, req_set,
                   e.hit, e.miss, e.pa, e.req, e.sl, e.st);
        end
      end
    end
  end

  bit finished = 0;
  initial begin : watchdog
    #(200000 * 4);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: empty after reset
    look(a_vpn(0), 13'h0, 1, 0, 0, '0, '0, "R1 empty after reset");
    for (int i = 0; i < 8; i++) fill(a_vpn(i), a_ppn(i), a_bin(i));
    // R3 R5: bin steering
    look(a_vpn(0), 13'h1abc, 1, 0, 1, a_ppn(0), a_bin(0), "R3 R5 bin mode entry0");
    look(a_vpn(5), 13'h0f80, 1, 0, 1, a_ppn(5), a_bin(5), "R5 bin mode entry5");
    look(a_vpn(7), 13'h1fff, 1, 0, 1, a_ppn(7), a_bin(7), "R5 bin mode entry7");
    // R6: modulo slice
    look(a_vpn(1), 13'h0555, 1, 1, 1, a_ppn(1), a_bin(1), "R6 shared mode entry1");
    look(a_vpn(6), 13'h1e00, 1, 1, 1, a_ppn(6), a_bin(6), "R6 shared mode entry6");
    // R4 R2
    look(a_vpn(2), 13'h0123, 0, 0, 1, a_ppn(2), a_bin(2), "R4 hit without l1 miss");
    look(20'hdead0, 13'h0040, 1, 0, 0, '0, '0, "R2 R4 unknown page miss");
    // R9: full buffer, pointer at entry0
    fill(20'h900, 20'h7777, 7'd99);
    look(a_vpn(0), 13'h0, 1, 0, 0, '0, '0, "R9 entry0 evicted");
    look(a_vpn(1), 13'h0, 1, 0, 1, a_ppn(1), a_bin(1), "R9 entry1 kept");
    look(20'h900, 13'h0380, 1, 0, 1, 20'h7777, 7'd99, "R3 R9 new page hits");
    fill(20'h901, 20'h7778, 7'd42);
    look(a_vpn(1), 13'h0, 1, 0, 0, '0, '0, "R9 pointer advanced to entry1");
    look(a_vpn(2), 13'h0, 1, 0, 1, a_ppn(2), a_bin(2), "R9 entry2 kept");
    // R7
    inval(a_vpn(3));
    look(a_vpn(3), 13'h0, 1, 0, 0, '0, '0, "R7 invalidated page misses");
    // R8: free slot used before pointer victim
    fill(20'h902, 20'h7779, 7'd127);
    look(a_vpn(2), 13'h0, 1, 0, 1, a_ppn(2), a_bin(2), "R8 free slot preferred");
    look(20'h902, 13'h1f80, 1, 0, 1, 20'h7779, 7'd127, "R8 refilled free slot");
    // R8: update in place
    fill(a_vpn(4), 20'h0abcd, 7'd64);
    look(a_vpn(4), 13'h0700, 1, 0, 1, 20'h0abcd, 7'd64, "R8 update in place");
    look(a_vpn(5), 13'h0, 1, 1, 1, a_ppn(5), a_bin(5), "R8 neighbour untouched");
    look(a_vpn(2), 13'h0, 1, 0, 1, a_ppn(2), a_bin(2), "R8 R9 no eviction on update");
    @(negedge clk); lk_valid = 0;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule